// File: doc/BRIEF.md
# Quadrature Position Tracker

This block turns the two phase signals and the once-per-turn marker of an incremental encoder into a position count, a turn count and a direction bit. Each of the three inputs first passes a stability filter with its own programmable length. The filtered phases are then decoded either as a quadrature pair, counting one or both phases, or as a step clock plus a direction level. Whether the count direction is flipped, and which marker polarity counts as active, is chosen at run time.

The position wraps between zero and a programmable limit in both directions. Three one-cycle control strobes clear the position, clear the turn count, or arm a one-shot clear of the position on the next marker. Four one-cycle event outputs report a marker, a change of direction, an illegal phase transition and every counted step. The inputs are expected to be synchronous to `clk` already.

Top module: `quad_pos_tracker`

## Requirements
- R1: After reset the position and turn count are 0, `dir_fwd` is 1 (forward) and all four event outputs are 0.
- R2: A filtered input takes a new raw level only after the raw level has differed from it on N+1 consecutive clock edges, N being that input's filter value; a deviation lasting N edges or fewer is ignored.
- R3: In quadrature mode with `cfg_four_x`=1 every single-phase transition moves the position by one; the order (A,B) = 00, 10, 11, 01, 00 counts forward and the reverse order counts backward.
- R4: In quadrature mode with `cfg_four_x`=0 only transitions of phase A move the position; transitions of phase B alone do not.
- R5: With `cfg_clk_dir`=1 each rising edge of filtered A moves the position by one, forward when B is 1 and backward when B is 0; falling A edges, B changes and `cfg_four_x` have no effect.
- R6: With `cfg_flip_dir`=1 the decoded direction is complemented for both the position update and `dir_fwd`.
- R7: Counting forward from a position at or above `pos_limit` gives 0; counting backward from 0 gives `pos_limit`.
- R8: In quadrature mode, a cycle in which both filtered phases change raises `ev_err` and leaves the position and `dir_fwd` unchanged; `ev_err` and `ev_step` are never high together.
- R9: A rising edge of the effective marker (filtered marker XOR `cfg_flip_idx`) raises `ev_index` and moves the turn count up by one if `dir_fwd` was 1, down by one (modulo 2^IDX_W) if it was 0.
- R10: Toggling `cfg_flip_idx` changes which raw marker edge is counted; a change of the flag that makes the effective marker rise counts as a marker edge.
- R11: `clr_pos` sets the position to 0 and `clr_turns` sets the turn count to 0 on the next edge, overriding any count in that cycle.
- R12: After `arm_idx_zero`, the next marker edge sets the position to 0 and the arming is used up; later markers leave the position alone.
- R13: Every counted step raises `ev_step` for one cycle and updates `dir_fwd`; `ev_dir` is high for one cycle when a counted step's direction differs from the previous `dir_fwd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Phase A, or step clock in clock/direction mode |
| enc_b | input | 1 | Phase B, or direction level in clock/direction mode |
| enc_x | input | 1 | Once-per-turn marker |
| cfg_clk_dir | input | 1 | 1 selects clock/direction decoding, 0 quadrature |
| cfg_four_x | input | 1 | 1 counts both phases, 0 only phase A (quadrature mode) |
| cfg_flip_dir | input | 1 | Complements the decoded direction |
| cfg_flip_idx | input | 1 | Inverts the marker polarity |
| pos_limit | input | POS_W | Largest position value before wrap |
| flt_a | input | FLT_W | Filter length for phase A |
| flt_b | input | FLT_W | Filter length for phase B |
| flt_x | input | FLT_W | Filter length for the marker |
| clr_pos | input | 1 | Strobe: clear the position |
| arm_idx_zero | input | 1 | Strobe: clear the position on the next marker |
| clr_turns | input | 1 | Strobe: clear the turn count |
| pos | output | POS_W | Current position |
| turns | output | IDX_W | Current turn count |
| dir_fwd | output | 1 | Direction of the last counted step, 1 = forward |
| ev_index | output | 1 | One-cycle pulse on a marker edge |
| ev_dir | output | 1 | One-cycle pulse on a direction change |
| ev_err | output | 1 | One-cycle pulse on an illegal phase transition |
| ev_step | output | 1 | One-cycle pulse on every counted step |

## Verification
Directed walks step the phase pair one transition at a time forward and backward in both edge-counting modes, so a count of 8 versus 4 for the same walk separates 4X from 2X and a wrong sign shows a swapped direction table. A diagonal jump of both phases separates a phase error from a count, and a reverse step at position 0 with a small limit exposes the wrap value. Clock/direction pulses with B held high then low, filter glitches of exactly the programmed length, and marker pulses with and without arming and polarity flip each isolate one mode. A long pseudo-random run of raw levels, hold times, strobes and mode changes is then compared cycle by cycle against a behavioural model to catch ordering and priority slips.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // Run-time decoding options gathered into one word.
  typedef struct packed {
    logic clk_dir;
    logic four_x;
    logic flip_dir;
    logic flip_idx;
  } qdec_mode_t;

  localparam int unsigned N_CH  = 3;
  localparam int unsigned CH_A  = 0;
  localparam int unsigned CH_B  = 1;
  localparam int unsigned CH_X  = 2;
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FLT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [FLT_W-1:0] thr,
  output logic             lvl
);
  localparam logic [FLT_W-1:0] CNT_ONE = FLT_W'(1);

  logic             lvl_q, lvl_d;
  logic [FLT_W-1:0] cnt_q, cnt_d;

  // Count consecutive cycles of disagreement; accept the raw level once the
  // run is longer than the programmed length.
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= thr) begin
      lvl_d = raw;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl = lvl_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == lvl_q) |=> $stable(lvl_q));
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw != lvl_q && cnt_q >= thr) |=> (lvl_q == $past(raw)));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic       x,
  input  qdec_mode_t mode,
  output logic       step,
  output logic       fwd,
  output logic       err,
  output logic       idx_rise
);
  logic pa_q, pb_q, px_q;
  logic da, db, raw_fwd, x_eff;

  always_comb begin
    da    = a ^ pa_q;
    db    = b ^ pb_q;
    x_eff = x ^ mode.flip_idx;
    if (mode.clk_dir) begin
      err     = 1'b0;
      step    = a & ~pa_q;
      raw_fwd = b;
    end else begin
      err     = da & db;
      step    = mode.four_x ? (da ^ db) : (da & ~db);
      // A leading B is forward: after an A edge the phases differ,
      // after a B edge they agree.
      raw_fwd = da ? (a ^ b) : ~(a ^ b);
    end
    fwd      = raw_fwd ^ mode.flip_dir;
    idx_rise = x_eff & ~px_q;
  end

  // The marker history holds the effective level, so a polarity change
  // that raises it is seen as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
      px_q <= 1'b0;
    end else begin
      pa_q <= a;
      pb_q <= b;
      px_q <= x_eff;
    end
  end

  p_clk_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.clk_dir && step) |-> (a && !$past(a)));
  p_two_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.clk_dir && !mode.four_x && step) |-> (a != $past(a)));
endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int POS_W = 16,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             fwd,
  input  logic             err,
  input  logic             idx_rise,
  input  logic [POS_W-1:0] limit,
  input  logic             clr_pos,
  input  logic             arm_zero,
  input  logic             clr_turns,
  output logic [POS_W-1:0] pos,
  output logic [IDX_W-1:0] turns,
  output logic             dir_fwd,
  output logic             ev_index,
  output logic             ev_dir,
  output logic             ev_err,
  output logic             ev_step
);
  localparam logic [POS_W-1:0] P_ONE = POS_W'(1);
  localparam logic [IDX_W-1:0] T_ONE = IDX_W'(1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] turn_q, turn_d;
  logic             dir_q, dir_d, arm_q, arm_d;
  logic [3:0]       ev_q, ev_d;

  always_comb begin
    pos_d  = pos_q;
    turn_d = turn_q;
    dir_d  = step ? fwd : dir_q;
    arm_d  = arm_q | arm_zero;

    if (clr_turns)     turn_d = '0;
    else if (idx_rise) turn_d = dir_q ? turn_q + T_ONE : turn_q - T_ONE;

    if (clr_pos) begin
      pos_d = '0;
    end else if (idx_rise && arm_q) begin
      pos_d = '0;
    end else if (step) begin
      if (fwd) pos_d = (pos_q >= limit) ? '0 : pos_q + P_ONE;
      else     pos_d = (pos_q == '0) ? limit : pos_q - P_ONE;
    end

    if (idx_rise && arm_q) arm_d = arm_zero;

    ev_d = {idx_rise, step & (fwd != dir_q), err, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      turn_q <= '0;
      dir_q  <= 1'b1;
      arm_q  <= 1'b0;
      ev_q   <= '0;
    end else begin
      pos_q  <= pos_d;
      turn_q <= turn_d;
      dir_q  <= dir_d;
      arm_q  <= arm_d;
      ev_q   <= ev_d;
    end
  end

  assign pos      = pos_q;
  assign turns    = turn_q;
  assign dir_fwd  = dir_q;
  assign ev_index = ev_q[3];
  assign ev_dir   = ev_q[2];
  assign ev_err   = ev_q[1];
  assign ev_step  = ev_q[0];

  p_clr_pos_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pos |=> (pos_q == '0));
  p_clr_turns_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_turns |=> (turn_q == '0));
  p_wrap_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fwd && pos_q >= limit && !clr_pos && !(idx_rise && arm_q))
      |=> (pos_q == '0));
  p_wrap_rev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fwd && pos_q == '0 && !clr_pos && !(idx_rise && arm_q))
      |=> (pos_q == $past(limit)));
  p_arm_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rise && arm_q) |=> (pos_q == '0));
  p_turn_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rise && dir_q && !clr_turns) |=> (turn_q == $past(turn_q) + T_ONE));
endmodule

// File: rtl/quad_pos_tracker.sv
module quad_pos_tracker
  import qdec_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int IDX_W = 16,
  parameter int FLT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_x,
  input  logic             cfg_clk_dir,
  input  logic             cfg_four_x,
  input  logic             cfg_flip_dir,
  input  logic             cfg_flip_idx,
  input  logic [POS_W-1:0] pos_limit,
  input  logic [FLT_W-1:0] flt_a,
  input  logic [FLT_W-1:0] flt_b,
  input  logic [FLT_W-1:0] flt_x,
  input  logic             clr_pos,
  input  logic             arm_idx_zero,
  input  logic             clr_turns,
  output logic [POS_W-1:0] pos,
  output logic [IDX_W-1:0] turns,
  output logic             dir_fwd,
  output logic             ev_index,
  output logic             ev_dir,
  output logic             ev_err,
  output logic             ev_step
);
  // Reset: asserted at once, released two edges later.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [N_CH-1:0]  raw_v, flt_v;
  logic [FLT_W-1:0] thr_v [N_CH];

  assign raw_v[CH_A] = enc_a;
  assign raw_v[CH_B] = enc_b;
  assign raw_v[CH_X] = enc_x;
  assign thr_v[CH_A] = flt_a;
  assign thr_v[CH_B] = flt_b;
  assign thr_v[CH_X] = flt_x;

  for (genvar g = 0; g < N_CH; g++) begin : g_flt
    qdec_filter #(.FLT_W(FLT_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .raw   (raw_v[g]),
      .thr   (thr_v[g]),
      .lvl   (flt_v[g])
    );
  end

  qdec_mode_t mode;
  assign mode = '{clk_dir: cfg_clk_dir, four_x: cfg_four_x,
                  flip_dir: cfg_flip_dir, flip_idx: cfg_flip_idx};

  logic step, fwd, err, idx_rise;

  qdec_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .a        (flt_v[CH_A]),
    .b        (flt_v[CH_B]),
    .x        (flt_v[CH_X]),
    .mode     (mode),
    .step     (step),
    .fwd      (fwd),
    .err      (err),
    .idx_rise (idx_rise)
  );

  qdec_count #(.POS_W(POS_W), .IDX_W(IDX_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .step      (step),
    .fwd       (fwd),
    .err       (err),
    .idx_rise  (idx_rise),
    .limit     (pos_limit),
    .clr_pos   (clr_pos),
    .arm_zero  (arm_idx_zero),
    .clr_turns (clr_turns),
    .pos       (pos),
    .turns     (turns),
    .dir_fwd   (dir_fwd),
    .ev_index  (ev_index),
    .ev_dir    (ev_dir),
    .ev_err    (ev_err),
    .ev_step   (ev_step)
  );

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(ev_err && ev_step));
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ev_err && !$past(clr_pos) && !$past(idx_rise)) |-> $stable(pos));
endmodule

// File: tb/sim_quad_pos_tracker.sv
`timescale 1ns/1ps
module sim_quad_pos_tracker;
  localparam int PW = 16;
  localparam int TW = 16;
  localparam int FW = 8;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic enc_a, enc_b, enc_x;
  logic cfg_clk_dir, cfg_four_x, cfg_flip_dir, cfg_flip_idx;
  logic [PW-1:0] pos_limit;
  logic [FW-1:0] flt_a, flt_b, flt_x;
  logic clr_pos, arm_idx_zero, clr_turns;
  logic [PW-1:0] pos;
  logic [TW-1:0] turns;
  logic dir_fwd, ev_index, ev_dir, ev_err, ev_step;

  quad_pos_tracker #(.POS_W(PW), .IDX_W(TW), .FLT_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_x(enc_x),
    .cfg_clk_dir(cfg_clk_dir), .cfg_four_x(cfg_four_x),
    .cfg_flip_dir(cfg_flip_dir), .cfg_flip_idx(cfg_flip_idx),
    .pos_limit(pos_limit), .flt_a(flt_a), .flt_b(flt_b), .flt_x(flt_x),
    .clr_pos(clr_pos), .arm_idx_zero(arm_idx_zero), .clr_turns(clr_turns),
    .pos(pos), .turns(turns), .dir_fwd(dir_fwd), .ev_index(ev_index),
    .ev_dir(ev_dir), .ev_err(ev_err), .ev_step(ev_step)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  int n_err = 0, n_step = 0, n_dirc = 0, n_idx = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Behavioural reference: levels accepted after a long enough run,
  // then edge interpretation, then counters.
  logic [PW-1:0] m_pos;
  logic [TW-1:0] m_turn;
  logic m_dir, m_arm, m_eidx, m_edir, m_eerr, m_estep;
  logic fl [3];
  int   fc [3];
  logic ha, hb, hx;
  logic da, db, st, fw, er, ir, cx, rw;
  int   th;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = '0; m_turn = '0; m_dir = 1'b1; m_arm = 1'b0;
      m_eidx = 0; m_edir = 0; m_eerr = 0; m_estep = 0;
      for (int k = 0; k < 3; k++) begin fl[k] = 1'b0; fc[k] = 0; end
      ha = 0; hb = 0; hx = 0;
    end else begin
      da = (fl[0] != ha);
      db = (fl[1] != hb);
      if (cfg_clk_dir) begin
        er = 0; st = fl[0] && !ha; fw = fl[1];
      end else begin
        er = da && db;
        st = cfg_four_x ? (da != db) : (da && !db);
        fw = da ? (fl[0] != fl[1]) : (fl[0] == fl[1]);
      end
      if (cfg_flip_dir) fw = !fw;
      cx = fl[2] ^ cfg_flip_idx;
      ir = cx && !hx;
      m_eidx = ir; m_eerr = er; m_estep = st; m_edir = st && (fw != m_dir);
      if (clr_turns) m_turn = '0;
      else if (ir) m_turn = m_dir ? m_turn + 16'd1 : m_turn - 16'd1;
      if (clr_pos) m_pos = '0;
      else if (ir && m_arm) m_pos = '0;
      else if (st) begin
        if (fw) m_pos = (m_pos >= pos_limit) ? '0 : m_pos + 16'd1;
        else    m_pos = (m_pos == 0) ? pos_limit : m_pos - 16'd1;
      end
      m_arm = arm_idx_zero || (m_arm && !ir);
      if (st) m_dir = fw;
      ha = fl[0]; hb = fl[1]; hx = cx;
      for (int k = 0; k < 3; k++) begin
        rw = (k == 0) ? enc_a : (k == 1) ? enc_b : enc_x;
        th = (k == 0) ? int'(flt_a) : (k == 1) ? int'(flt_b) : int'(flt_x);
        if (rw == fl[k]) fc[k] = 0;
        else if (fc[k] >= th) begin fl[k] = rw; fc[k] = 0; end
        else fc[k] = fc[k] + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      chk("R3 position vs model", int'(pos), int'(m_pos));
      chk("R9 turns vs model", int'(turns), int'(m_turn));
      chk("R13 dir_fwd vs model", int'(dir_fwd), int'(m_dir));
      chk("R9 ev_index vs model", int'(ev_index), int'(m_eidx));
      chk("R13 ev_dir vs model", int'(ev_dir), int'(m_edir));
      chk("R8 ev_err vs model", int'(ev_err), int'(m_eerr));
      chk("R13 ev_step vs model", int'(ev_step), int'(m_estep));
      n_err += int'(ev_err); n_step += int'(ev_step);
      n_dirc += int'(ev_dir); n_idx += int'(ev_index);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  int q = 0;
  task automatic put(input logic a, input logic b);
    enc_a = a; enc_b = b; tick(HOLD);
  endtask
  task automatic go(input bit fwd_step);
    q = fwd_step ? (q + 1) % 4 : (q + 3) % 4;
    put(q == 1 || q == 2, q == 2 || q == 3);
  endtask
  task automatic marker;
    enc_x = 1'b1; tick(HOLD); enc_x = 1'b0; tick(HOLD);
  endtask
  task automatic zero_pos;
    clr_pos = 1'b1; tick(1); clr_pos = 1'b0; tick(2);
  endtask

  int s0;

  initial begin
    rst_n = 1'b0;
    enc_a = 0; enc_b = 0; enc_x = 0;
    cfg_clk_dir = 0; cfg_four_x = 1; cfg_flip_dir = 0; cfg_flip_idx = 0;
    pos_limit = 16'd99; flt_a = 0; flt_b = 0; flt_x = 0;
    clr_pos = 0; arm_idx_zero = 0; clr_turns = 0;
    tick(4);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 pos after reset", int'(pos), 0);
    chk("R1 turns after reset", int'(turns), 0);
    chk("R1 dir after reset", int'(dir_fwd), 1);
    chk("R1 events after reset", int'({ev_index, ev_dir, ev_err, ev_step}), 0);
    run = 1'b1;

    // R3 4X forward and reverse, R13 events
    s0 = n_step;
    for (int i = 0; i < 8; i++) go(1);
    chk("R3 4X forward 8 edges", int'(pos), 8);
    chk("R13 step pulses", n_step - s0, 8);
    s0 = n_dirc;
    for (int i = 0; i < 3; i++) go(0);
    chk("R3 4X reverse 3 edges", int'(pos), 5);
    chk("R13 dir after reverse", int'(dir_fwd), 0);
    chk("R13 one dir change pulse", n_dirc - s0, 1);

    // R4 2X counting
    cfg_four_x = 0; zero_pos();
    for (int i = 0; i < 8; i++) go(1);
    chk("R4 2X forward 8 edges", int'(pos), 4);
    chk("R4 dir forward", int'(dir_fwd), 1);

    // R8 phase error
    cfg_four_x = 1; zero_pos();
    s0 = n_err;
    q = (q + 2) % 4; put(q == 1 || q == 2, q == 2 || q == 3);
    chk("R8 error pulse", n_err - s0, 1);
    chk("R8 no count on error", int'(pos), 0);

    // R7 wrap
    pos_limit = 16'd5; zero_pos();
    go(0);
    chk("R7 reverse from 0 gives limit", int'(pos), 5);
    go(1);
    chk("R7 forward from limit gives 0", int'(pos), 0);

    // R5 clock/direction
    pos_limit = 16'd99; cfg_clk_dir = 1; zero_pos();
    put(0, 1);
    for (int i = 0; i < 3; i++) begin put(1, 1); put(0, 1); end
    chk("R5 three forward clocks", int'(pos), 3);
    cfg_four_x = 0;
    put(0, 0);
    for (int i = 0; i < 2; i++) begin put(1, 0); put(0, 0); end
    chk("R5 two reverse clocks, 4X ignored", int'(pos), 1);
    chk("R5 direction low", int'(dir_fwd), 0);
    cfg_four_x = 1; cfg_clk_dir = 0; q = 0; tick(2);

    // R6 direction flip
    cfg_flip_dir = 1; zero_pos();
    go(1); go(1);
    chk("R6 flipped forward counts down", int'(pos), 98);
    chk("R6 flipped dir bit", int'(dir_fwd), 0);
    cfg_flip_dir = 0;

    // R9 / R12 / R10 marker handling
    go(1);
    zero_pos();
    clr_turns = 1; tick(1); clr_turns = 0; tick(2);
    chk("R11 turns cleared", int'(turns), 0);
    marker();
    chk("R9 forward marker", int'(turns), 1);
    go(0);
    marker();
    chk("R9 reverse marker", int'(turns), 0);
    arm_idx_zero = 1; tick(1); arm_idx_zero = 0; tick(2);
    go(1); go(1);
    chk("R12 armed, before marker", int'(pos), 1);
    marker();
    chk("R12 marker zeroes position", int'(pos), 0);
    go(1);
    marker();
    chk("R12 arming used up", int'(pos), 1);
    chk("R9 turns after markers", int'(turns), 2);
    cfg_flip_idx = 1; tick(HOLD);
    chk("R10 polarity flip counts as edge", int'(turns), 3);
    marker();
    chk("R10 inverted marker counted once", int'(turns), 4);
    cfg_flip_idx = 0; tick(HOLD);
    chk("R10 flip back adds nothing", int'(turns), 4);

    // R2 filter
    flt_a = 8'd3; zero_pos();
    enc_a = ~enc_a; tick(3); enc_a = ~enc_a; tick(HOLD);
    chk("R2 glitch of filter length ignored", int'(pos), 0);
    go(1); go(1);
    chk("R2 held levels pass", int'(pos), 2);

    // Mixed pseudo-random run against the model
    for (int i = 0; i < 700; i++) begin
      if (i % 60 == 0) begin
        cfg_clk_dir = ($urandom % 4) == 0;
        cfg_four_x = $urandom % 2; cfg_flip_dir = $urandom % 2;
        cfg_flip_idx = $urandom % 2;
        pos_limit = 16'(4 + $urandom % 20);
        flt_a = 8'($urandom % 3); flt_b = 8'($urandom % 3); flt_x = 8'($urandom % 3);
      end
      enc_a = $urandom % 2; enc_b = $urandom % 2;
      enc_x = ($urandom % 5) == 0;
      clr_pos = ($urandom % 40) == 0;
      clr_turns = ($urandom % 40) == 0;
      arm_idx_zero = ($urandom % 15) == 0;
      tick(1);
      clr_pos = 0; clr_turns = 0; arm_idx_zero = 0;
      tick($urandom % 4);
    end
    tick(6);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule